// File: doc/BRIEF.md
# Triplicated Instruction Memory with Voted Background Scrubber

This block holds three identical copies of a program memory and supplies a processor fetch port with the bitwise two-of-three majority of the three words read at the fetch address. A single upset in any one copy is therefore invisible at the output. Upsets still pile up over time, and two of them in the same bit of the same word would defeat the vote. To prevent that, a background scrubber visits every address in turn and writes the voted word back into all three copies.

The scrubber is triplicated as well. Each copy has its own phase register, its own address counter, its own hold register and its own write enable, and it drives only its own memory. The three phase registers and the three address counters are voted together at every step, so the copies stay in lockstep. Each scrub step takes two memory cycles: a read on the scrub port, then a write-back. The scrubber never writes the word being fetched. When its write address matches the fetch address, it waits. Outside of scrub writes the memories are read-only. Clock and reset are shared.

A set of bit-flip inputs models single-event upsets in a chosen copy. A reset reloads all three copies with the program image.

Top module: `tmr_imem_scrub`

## Requirements
- R1: While `rst` is high, `fetch_instr` is 0. After reset, `fetch_instr` presents, one clock after `fetch_addr` is applied, the word at that address. The program image at address a is the low DATA_W bits of (a * 40503) XOR 0xA5C3.
- R2: An upset in a single copy of a word leaves `fetch_instr` equal to the image word. An upset is `flip_en` high for one clock, with `flip_copy` set to 0, 1 or 2 to select the copy, and `flip_mask` XORed into the word at `flip_addr`.
- R3: Upsets in two copies of the same word, in bits that do not overlap, leave `fetch_instr` equal to the image word.
- R4: An upset is rewritten with the voted word no later than 4*DEPTH+8 clocks after it is applied, while the fetch address keeps moving. This holds for one-copy upsets and for non-overlapping two-copy upsets.
- R5: The scrubber uses one clock to read an address and the next clock to write it back. It covers every address from 0 up to DEPTH-1, wraps to 0 and runs without end. The three controller copies hold the same address at all times.
- R6: No scrub write lands on the address being fetched in the same clock. When the scrub write address equals `fetch_addr`, the write is held back and the scrubber waits at that address until the fetch address moves away. It then writes the word it read earlier.
- R7: A reset reloads every copy with the program image, and discards any upsets applied before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared memory and scrubber clock |
| rst | input | 1 | Synchronous active-high reset; reloads the image |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| fetch_instr | output | DATA_W | Voted instruction, registered |
| flip_en | input | 1 | Apply an upset this clock |
| flip_copy | input | 2 | Copy hit by the upset (0..2) |
| flip_addr | input | ADDR_W | Word hit by the upset |
| flip_mask | input | DATA_W | Bits inverted by the upset |

## Verification
The hardest case to reach is a collision between the fetch and the scrubber. The scrubber has to be stopped at an address and still hold the word it read there, and then it has to be let go. The stimulus parks the fetch address on one word long enough for the scrubber to arrive and stall there, with one copy of that word upset. A second upset in the same bit of a third copy then acts as a probe. Reading the wrong majority shows that the write was held back. Moving the fetch away and reading the correct word shows that the held word was written back. Repair after a normal pass is shown in the same way: after the wait, an upset goes into the same bit of a copy that was clean, and the output must still show the image word.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;

    // Number of redundant memory and controller copies.
    localparam int NCOPY = 3;

    // Constants of the program image formula.
    localparam logic [31:0] IMG_MULT = 32'd40503;
    localparam logic [31:0] IMG_XOR  = 32'h0000_A5C3;

    // Two-cycle scrub step: read the scrub port, then write the word back.
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } scrub_phase_e;

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    // Bitwise two-of-three majority.
    assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_mem_copy.sv
module tmr_mem_copy
    import tmr_scrub_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int COPY_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    // fetch read port
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    // scrub read port
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    // scrub write port, owned by this copy's controller only
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    // upset model
    input  logic              flip_en,
    input  logic [1:0]        flip_copy,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [DATA_W-1:0] flip_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              flip_hit;

    function automatic logic [DATA_W-1:0] image_word(input int unsigned idx);
        return DATA_W'((32'(idx) * IMG_MULT) ^ IMG_XOR);
    endfunction

    assign flip_hit = flip_en && (flip_copy == 2'(COPY_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= image_word(i);
            end
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
            end
            // an upset in the same clock overrides the scrub write
            if (flip_hit) begin
                mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
            end
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

endmodule

// File: rtl/tmr_scrub_ctrl.sv
module tmr_scrub_ctrl
    import tmr_scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    // voted state from all controller copies
    input  scrub_phase_e      phase_v,
    input  logic [ADDR_W-1:0] addr_v,
    input  logic [DATA_W-1:0] scrub_word,
    input  logic [ADDR_W-1:0] fetch_addr,
    // this copy's own state
    output scrub_phase_e      phase_q,
    output logic [ADDR_W-1:0] addr_q,
    // this copy's own write port
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] hold_q;
    logic              collide_v;

    assign collide_v = (addr_v == fetch_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_READ;
            addr_q  <= '0;
            hold_q  <= '0;
        end else begin
            case (phase_v)
                PH_READ: begin
                    phase_q <= PH_WRITE;
                    addr_q  <= addr_v;
                    hold_q  <= scrub_word;
                end
                default: begin
                    if (collide_v) begin
                        phase_q <= PH_WRITE;
                        addr_q  <= addr_v;
                    end else begin
                        phase_q <= PH_READ;
                        addr_q  <= ADDR_W'(addr_v + 1'b1);
                    end
                end
            endcase
        end
    end

    // The enable comes from this copy's own registers only.
    assign we    = (phase_q == PH_WRITE) && (addr_q != fetch_addr);
    assign waddr = addr_q;
    assign wdata = hold_q;

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase_v == PH_READ) |=> (phase_q == PH_WRITE)); // R5

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (phase_v == PH_WRITE && !collide_v)
        |=> (phase_q == PH_READ && addr_q == ADDR_W'($past(addr_v) + 1'b1))); // R5

    AST_WAIT_ON_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (phase_v == PH_WRITE && collide_v)
        |=> (phase_q == PH_WRITE && addr_q == $past(addr_v))); // R6

endmodule

// File: rtl/tmr_imem_scrub.sv
module tmr_imem_scrub
    import tmr_scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_instr,
    input  logic              flip_en,
    input  logic [1:0]        flip_copy,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [DATA_W-1:0] flip_mask
);
    logic [DATA_W-1:0] rd_fetch [NCOPY];
    logic [DATA_W-1:0] rd_scrub [NCOPY];
    logic              mem_we   [NCOPY];
    logic [ADDR_W-1:0] mem_wa   [NCOPY];
    logic [DATA_W-1:0] mem_wd   [NCOPY];
    scrub_phase_e      ph_q     [NCOPY];
    logic [ADDR_W-1:0] ad_q     [NCOPY];
    logic [NCOPY-1:0]  ph_bits;

    logic              ph_vote;
    scrub_phase_e      phase_v;
    logic [ADDR_W-1:0] addr_v;
    logic [DATA_W-1:0] fetch_vote;
    logic [DATA_W-1:0] scrub_vote;

    // controller state voting
    tmr_vote #(.W(1)) u_vote_phase (
        .a(ph_bits[0]), .b(ph_bits[1]), .c(ph_bits[2]), .y(ph_vote)
    );
    assign phase_v = scrub_phase_e'(ph_vote);

    tmr_vote #(.W(ADDR_W)) u_vote_addr (
        .a(ad_q[0]), .b(ad_q[1]), .c(ad_q[2]), .y(addr_v)
    );

    // data voting for both read ports
    tmr_vote #(.W(DATA_W)) u_vote_fetch (
        .a(rd_fetch[0]), .b(rd_fetch[1]), .c(rd_fetch[2]), .y(fetch_vote)
    );
    tmr_vote #(.W(DATA_W)) u_vote_scrub (
        .a(rd_scrub[0]), .b(rd_scrub[1]), .c(rd_scrub[2]), .y(scrub_vote)
    );

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        assign ph_bits[k] = ph_q[k];

        tmr_scrub_ctrl #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
        ) u_ctrl (
            .clk       (clk),
            .rst       (rst),
            .phase_v   (phase_v),
            .addr_v    (addr_v),
            .scrub_word(scrub_vote),
            .fetch_addr(fetch_addr),
            .phase_q   (ph_q[k]),
            .addr_q    (ad_q[k]),
            .we        (mem_we[k]),
            .waddr     (mem_wa[k]),
            .wdata     (mem_wd[k])
        );

        tmr_mem_copy #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .COPY_ID(k)
        ) u_mem (
            .clk      (clk),
            .rst      (rst),
            .rd_addr_a(fetch_addr),
            .rd_data_a(rd_fetch[k]),
            .rd_addr_b(addr_v),
            .rd_data_b(rd_scrub[k]),
            .wr_en    (mem_we[k]),
            .wr_addr  (mem_wa[k]),
            .wr_data  (mem_wd[k]),
            .flip_en  (flip_en),
            .flip_copy(flip_copy),
            .flip_addr(flip_addr),
            .flip_mask(flip_mask)
        );

        AST_NO_FETCH_WRITE: assert property (@(posedge clk) disable iff (rst)
            mem_we[k] |-> (mem_wa[k] != fetch_addr)); // R6
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_instr <= '0;
        end else begin
            fetch_instr <= fetch_vote;
        end
    end

    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
        (ad_q[0] == ad_q[1]) && (ad_q[1] == ad_q[2])
        && (ph_q[0] == ph_q[1]) && (ph_q[1] == ph_q[2])); // R5

    AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (rst)
        (mem_we[0] == mem_we[1]) && (mem_we[1] == mem_we[2])); // R5

endmodule

// File: tb/tmr_imem_scrub_bench.sv
module tmr_imem_scrub_bench;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int PASS  = 4 * DEPTH + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic [DW-1:0] fetch_instr;
    logic          flip_en = 1'b0;
    logic [1:0]    flip_copy = '0;
    logic [AW-1:0] flip_addr = '0;
    logic [DW-1:0] flip_mask = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_imem_scrub #(.ADDR_W(AW), .DATA_W(DW)) u_tmr_imem_scrub (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
        .flip_en(flip_en), .flip_copy(flip_copy), .flip_addr(flip_addr),
        .flip_mask(flip_mask)
    );

    function automatic logic [DW-1:0] img(input int a);
        logic [31:0] t;
        t = (32'(a) * 32'd40503) ^ 32'h0000A5C3;
        return t[DW-1:0];
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic fetch(input int a, output logic [DW-1:0] v);
        @(negedge clk) fetch_addr = AW'(a);
        @(negedge clk) v = fetch_instr;
    endtask

    task automatic upset(input int copy, input int a, input logic [DW-1:0] m);
        @(negedge clk);
        flip_en = 1'b1; flip_copy = 2'(copy); flip_addr = AW'(a); flip_mask = m;
        @(negedge clk);
        flip_en = 1'b0; flip_mask = '0;
    endtask

    // moving fetch address, as a running processor would produce
    task automatic sweep(input int n);
        repeat (n) @(negedge clk) fetch_addr = fetch_addr + 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R1 reset output", fetch_instr, '0);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_clean_reads();
        logic [DW-1:0] v;
        foreach (int_list[i]) begin
            fetch(int_list[i], v);
            chk("R1 clean read", v, img(int_list[i]));
        end
    endtask
    int int_list[5] = '{0, 1, 17, 42, DEPTH - 1};

    task automatic t_single();
        logic [DW-1:0] v;
        upset(1, 9, 16'h0020);
        fetch(9, v);
        chk("R2 one copy upset", v, img(9));
        sweep(PASS);
        upset(0, 9, 16'h0020);
        fetch(9, v);
        chk("R4 single repaired", v, img(9));
        sweep(PASS);
    endtask

    task automatic t_double();
        logic [DW-1:0] v;
        upset(0, 30, 16'h0008);
        upset(1, 30, 16'h0080);
        fetch(30, v);
        chk("R3 two copy upset", v, img(30));
        sweep(PASS);
        upset(2, 30, 16'h0088);
        fetch(30, v);
        chk("R4 double repaired", v, img(30));
        sweep(PASS);
    endtask

    task automatic t_edges();
        logic [DW-1:0] v;
        upset(2, DEPTH - 1, 16'h8000);
        upset(1, 0, 16'h0001);
        sweep(PASS);
        upset(0, DEPTH - 1, 16'h8000);
        upset(0, 0, 16'h0001);
        fetch(DEPTH - 1, v);
        chk("R5 last address scrubbed", v, img(DEPTH - 1));
        fetch(0, v);
        chk("R5 wrap to address zero", v, img(0));
        sweep(PASS);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        @(negedge clk) fetch_addr = AW'(20);
        upset(0, 20, 16'h0001);
        repeat (PASS) @(negedge clk);
        upset(2, 20, 16'h0001);
        fetch(20, v);
        chk("R6 write held off at fetch address", v, img(20) ^ 16'h0001);
        fetch(25, v);
        sweep(10);
        fetch(20, v);
        chk("R6 held word written after release", v, img(20));
        sweep(PASS);
    endtask

    task automatic t_reload();
        logic [DW-1:0] v;
        upset(0, 3, 16'h0F00);
        upset(1, 3, 16'h00F0);
        upset(2, 3, 16'h0F00);
        fetch(3, v);
        chk("R7 corrupted before reset", v, img(3) ^ 16'h0F00);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R1 output zero in reset", fetch_instr, '0);
        @(negedge clk) rst = 1'b0;
        fetch(3, v);
        chk("R7 image reloaded", v, img(3));
    endtask

    initial begin
        t_reset_state();
        t_clean_reads();
        t_single();
        t_double();
        t_edges();
        t_collide();
        t_reload();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule